// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects every cause that can restart the chip and turns them into two reset outputs. `chip_rst` clears everything. `part_rst` clears everything except two registers that software keeps: the self-control register and the I/O base register. The causes are:
- loss of power or of a stable oscillator;
- an external reset pin held high long enough;
- a checksum-error strobe from the configuration loader;
- a software reset bit;
- entry to or exit from the hardware standby and suspend modes;
- the software suspend mode.

Short events are stretched into a reset of fixed length. Loss of power asserts reset at once, without waiting for a clock edge. Release is always aligned to the clock.

Once every reset has ended, an initialization phase of a programmable number of cycles runs. `init_busy` is high and `init_done` is low while it runs. The block also owns the signature readback port. After any reset it returns 16'h3000, and keeps doing so until software stores a non-zero value there. All inputs except `pwr_good` and `osc_stable` are synchronous to `clk`.

Top module: `rst_sequencer`

## Requirements
- R1: While `pwr_good` or `osc_stable` is low, `chip_rst` is high, and it rises without waiting for a clock edge. Once both are high, `chip_rst` falls after the second rising clock edge, provided no other cause is pending.
- R2: An `ext_rst` level that stays high for THRESH = ceil(MIN_PULSE_PS / CLK_PERIOD_PS) consecutive rising edges (50 at the defaults) raises `chip_rst` from the next cycle on. Reset then stays high while the pin stays high, plus HOLD_CYCLES cycles after the last qualified edge. A pulse that lasts one cycle fewer causes no reset.
- R3: A one-cycle `cksum_err` strobe makes `chip_rst` high for exactly HOLD_CYCLES cycles, starting in the cycle after the strobe.
- R4: Writing `ctl_wdata` with bit 6 set through `ctl_wr`, outside reset, causes a chip reset of HOLD_CYCLES cycles. The chip reset clears `ctl_q`, so the bit clears itself. Writes made while `chip_rst` is high are ignored.
- R5: Every change of `hw_standby` or `hw_suspend`, rising or falling, causes a chip reset of HOLD_CYCLES cycles.
- R6: While `sw_suspend` is high, `part_rst` is high and `chip_rst` is not.
  - `ctl_q` and `base_q` keep their values.
  - `sig_rdata` returns to 16'h3000.
  - `init_done` is low.
- R7: The falling edge of `sw_suspend` causes a chip reset of HOLD_CYCLES cycles, which also clears `ctl_q` and `base_q`.
- R8: After `part_rst` falls, `init_busy` stays high and `init_done` stays low until `init_done` rises on the INIT_CYCLES-th rising edge. `init_busy` is always the inverse of `init_done`.
- R9: After any reset, `sig_rdata` reads 16'h3000. While it does, writes of zero through `sig_wr` are ignored. The first non-zero write, and every write after it, sets the value that is read back.
- R10: Causes that coincide, or that arrive during a reset, give one reset that ends HOLD_CYCLES cycles after the last of them. A register write in the same cycle as a reset cause does not survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supply in range (asynchronous) |
| osc_stable | input | 1 | Oscillator settled (asynchronous) |
| ext_rst | input | 1 | External reset pin, active high |
| cksum_err | input | 1 | Configuration checksum error strobe |
| hw_standby | input | 1 | Hardware standby request level |
| hw_suspend | input | 1 | Hardware suspend request level |
| sw_suspend | input | 1 | Software suspend request level |
| ctl_wr | input | 1 | Write strobe for the self-control register |
| ctl_wdata | input | REG_W | Self-control write data (bit 6 = reset) |
| base_wr | input | 1 | Write strobe for the I/O base register |
| base_wdata | input | REG_W | I/O base write data |
| sig_wr | input | 1 | Write strobe for the signature offset |
| sig_wdata | input | REG_W | Signature offset write data |
| chip_rst | output | 1 | Chip-wide reset |
| part_rst | output | 1 | Partial reset (spares self-control and base) |
| init_done | output | 1 | Initialization complete |
| init_busy | output | 1 | Initialization in progress |
| ctl_q | output | REG_W | Self-control register value |
| base_q | output | REG_W | I/O base register value |
| sig_rdata | output | REG_W | Signature offset readback |

## Verification
A reset cause can arrive in the same cycle as a register write, so reset and update compete for one clock edge. The bench provokes this in one cycle with three stimuli:
- a checksum strobe;
- a self-control write with bit 6 set;
- a non-zero signature write.

It passes only if all of the following hold:
- a single reset of exactly HOLD_CYCLES cycles follows;
- `sig_rdata` is back at 16'h3000 afterwards;
- `ctl_q` is zero afterwards.

A second collision places a self-control write inside an active reset and checks that the write is lost.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  // Number of whole clock cycles that cover a time span (rounded up).
  function automatic int unsigned cycles_for(int unsigned span_ps, int unsigned period_ps);
    return (span_ps + period_ps - 1) / period_ps;
  endfunction

  // Bits needed to hold values 0..max_val.
  function automatic int unsigned cnt_bits(int unsigned max_val);
    int unsigned b;
    b = 1;
    while ((64'(1) << b) <= 64'(max_val)) b++;
    return b;
  endfunction

endpackage

// File: rtl/rst_pulse_qual.sv
module rst_pulse_qual
  import rst_seq_pkg::*;
#(
  parameter int unsigned THRESH = 50
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin,
  output logic long_hi
);
  localparam int unsigned W = cnt_bits(THRESH);

  logic [W-1:0] cnt;

  // Counts consecutive high cycles, saturates at THRESH, clears when low.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                 cnt <= '0;
    else if (!pin)               cnt <= '0;
    else if (cnt != W'(THRESH))  cnt <= cnt + 1'b1;
  end

  assign long_hi = (cnt == W'(THRESH));
endmodule

// File: rtl/rst_merge.sv
module rst_merge
  import rst_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic pwr_ok,
  input  logic ev_any,
  output logic por_rst,
  output logic chip_rst
);
  localparam int unsigned HW = cnt_bits(HOLD_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hold;

  // Asynchronous assertion, clock-aligned release of the power reset.
  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign por_rst = ~sync_q[SYNC_STAGES-1];

  // Stretch of event-driven resets; any new event restarts the window.
  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok)         hold <= '0;
    else if (ev_any)     hold <= HW'(HOLD_CYCLES);
    else if (hold != '0) hold <= hold - 1'b1;
  end

  assign chip_rst = por_rst | (hold != '0);
endmodule

// File: rtl/init_tracker.sv
module init_tracker
  import rst_seq_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 1250000
) (
  input  logic clk,
  input  logic pwr_ok,
  input  logic clr,
  output logic done,
  output logic busy
);
  localparam int unsigned CW = cnt_bits(INIT_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == CW'(INIT_CYCLES - 1)) done <= 1'b1;
      else                             cnt  <= cnt + 1'b1;
    end
  end

  assign busy = ~done;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned MIN_PULSE_PS  = 400000,
  parameter int unsigned HOLD_CYCLES   = 8,
  parameter int unsigned INIT_CYCLES   = 1250000,
  parameter int unsigned REG_W         = 16,
  parameter int unsigned SWRST_BIT     = 6,
  parameter logic [15:0] SIG_VALUE     = 16'h3000
) (
  input  logic             clk,
  input  logic             pwr_good,
  input  logic             osc_stable,
  input  logic             ext_rst,
  input  logic             cksum_err,
  input  logic             hw_standby,
  input  logic             hw_suspend,
  input  logic             sw_suspend,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             base_wr,
  input  logic [REG_W-1:0] base_wdata,
  input  logic             sig_wr,
  input  logic [REG_W-1:0] sig_wdata,
  output logic             chip_rst,
  output logic             part_rst,
  output logic             init_done,
  output logic             init_busy,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] base_q,
  output logic [REG_W-1:0] sig_rdata
);
  localparam int unsigned THRESH = cycles_for(MIN_PULSE_PS, CLK_PERIOD_PS);

  logic pwr_ok;
  logic por_rst;
  logic stby_q, susp_q, ssusp_q;
  logic ev_ext, ev_cksum, ev_sw, ev_mode, ev_any;
  logic sig_set;
  logic [REG_W-1:0] sig_val;

  assign pwr_ok = pwr_good & osc_stable;

  rst_pulse_qual #(.THRESH(THRESH)) u_qual (
    .clk     (clk),
    .arst_n  (pwr_ok),
    .pin     (ext_rst),
    .long_hi (ev_ext)
  );

  // Mode level history; only power loss clears it, so a chip reset
  // cannot fake a mode edge.
  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      stby_q  <= 1'b0;
      susp_q  <= 1'b0;
      ssusp_q <= 1'b0;
    end else begin
      stby_q  <= hw_standby;
      susp_q  <= hw_suspend;
      ssusp_q <= sw_suspend;
    end
  end

  assign ev_cksum = cksum_err;
  assign ev_sw    = ctl_wr & ctl_wdata[SWRST_BIT] & ~chip_rst;
  assign ev_mode  = (hw_standby ^ stby_q) | (hw_suspend ^ susp_q) | (ssusp_q & ~sw_suspend);
  assign ev_any   = ev_ext | ev_cksum | ev_sw | ev_mode;

  rst_merge #(.HOLD_CYCLES(HOLD_CYCLES), .SYNC_STAGES(2)) u_merge (
    .clk      (clk),
    .pwr_ok   (pwr_ok),
    .ev_any   (ev_any),
    .por_rst  (por_rst),
    .chip_rst (chip_rst)
  );

  assign part_rst = chip_rst | ssusp_q;

  init_tracker #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk    (clk),
    .pwr_ok (pwr_ok),
    .clr    (part_rst),
    .done   (init_done),
    .busy   (init_busy)
  );

  // Registers that survive a partial reset.
  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      ctl_q  <= '0;
      base_q <= '0;
    end else if (chip_rst) begin
      ctl_q  <= '0;
      base_q <= '0;
    end else begin
      if (ctl_wr)  ctl_q  <= ctl_wdata;
      if (base_wr) base_q <= base_wdata;
    end
  end

  // Signature offset: fixed pattern until a non-zero value is stored.
  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      sig_set <= 1'b0;
      sig_val <= '0;
    end else if (part_rst) begin
      sig_set <= 1'b0;
      sig_val <= '0;
    end else if (sig_wr && (sig_set || (sig_wdata != '0))) begin
      sig_set <= 1'b1;
      sig_val <= sig_wdata;
    end
  end

  assign sig_rdata = sig_set ? sig_val : REG_W'(SIG_VALUE);

  // Unused but kept visible for the bound checker.
  logic unused_por;
  assign unused_por = por_rst;
endmodule

// File: rtl/rst_seq_checker.sv
module rst_seq_checker #(
  parameter int unsigned REG_W     = 16,
  parameter int unsigned SWRST_BIT = 6,
  parameter logic [15:0] SIG_VALUE = 16'h3000
) (
  input logic             clk,
  input logic             pwr_good,
  input logic             osc_stable,
  input logic             cksum_err,
  input logic             sw_suspend,
  input logic             ctl_wr,
  input logic [REG_W-1:0] ctl_wdata,
  input logic             base_wr,
  input logic             ev_ext,
  input logic             ev_mode,
  input logic             chip_rst,
  input logic             part_rst,
  input logic             init_done,
  input logic [REG_W-1:0] base_q,
  input logic [REG_W-1:0] sig_rdata
);
  logic pwr_ok;
  assign pwr_ok = pwr_good & osc_stable;

  always @(negedge clk) begin
    if (!pwr_ok) begin
      a_r1_held_without_power: assert (chip_rst) else $error("R1 chip_rst low while power bad");
    end
  end

  a_r2_long_pin_resets: assert property (@(posedge clk) disable iff (!pwr_ok)
    ev_ext |=> chip_rst);

  a_r3_cksum_resets: assert property (@(posedge clk) disable iff (!pwr_ok)
    cksum_err |=> chip_rst);

  a_r4_swbit_resets: assert property (@(posedge clk) disable iff (!pwr_ok)
    (ctl_wr && ctl_wdata[SWRST_BIT] && !chip_rst) |=> chip_rst);

  a_r5_mode_edge_resets: assert property (@(posedge clk) disable iff (!pwr_ok)
    ev_mode |=> chip_rst);

  a_r6_suspend_partial: assert property (@(posedge clk) disable iff (!pwr_ok)
    sw_suspend |=> part_rst);

  a_r6_base_kept: assert property (@(posedge clk) disable iff (!pwr_ok)
    (!chip_rst && !base_wr) |=> $stable(base_q));

  a_r8_done_cleared: assert property (@(posedge clk) disable iff (!pwr_ok)
    part_rst |=> !init_done);

  a_r9_signature_restored: assert property (@(posedge clk) disable iff (!pwr_ok)
    part_rst |=> (sig_rdata == REG_W'(SIG_VALUE)));

  a_r10_chip_implies_part: assert property (@(posedge clk) disable iff (!pwr_ok)
    chip_rst |-> part_rst);
endmodule

bind rst_sequencer rst_seq_checker #(
  .REG_W(REG_W), .SWRST_BIT(SWRST_BIT), .SIG_VALUE(SIG_VALUE)
) u_chk (
  .clk        (clk),
  .pwr_good   (pwr_good),
  .osc_stable (osc_stable),
  .cksum_err  (cksum_err),
  .sw_suspend (sw_suspend),
  .ctl_wr     (ctl_wr),
  .ctl_wdata  (ctl_wdata),
  .base_wr    (base_wr),
  .ev_ext     (ev_ext),
  .ev_mode    (ev_mode),
  .chip_rst   (chip_rst),
  .part_rst   (part_rst),
  .init_done  (init_done),
  .base_q     (base_q),
  .sig_rdata  (sig_rdata)
);

// File: tb/sim_rst_sequencer.sv
`timescale 1ns/1ps
module sim_rst_sequencer;
  localparam int PER_PS = 8000;
  localparam int MIN_PS = 400000;
  localparam int HOLD   = 8;
  localparam int INIT   = 40;
  localparam int THR    = (MIN_PS + PER_PS - 1) / PER_PS;   // 50

  logic clk = 1'b0;
  logic pwr_good = 1'b0, osc_stable = 1'b0, ext_rst = 1'b0, cksum_err = 1'b0;
  logic hw_standby = 1'b0, hw_suspend = 1'b0, sw_suspend = 1'b0;
  logic ctl_wr = 1'b0, base_wr = 1'b0, sig_wr = 1'b0;
  logic [15:0] ctl_wdata = '0, base_wdata = '0, sig_wdata = '0;
  logic chip_rst, part_rst, init_done, init_busy;
  logic [15:0] ctl_q, base_q, sig_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rst_sequencer #(
    .CLK_PERIOD_PS(PER_PS), .MIN_PULSE_PS(MIN_PS),
    .HOLD_CYCLES(HOLD), .INIT_CYCLES(INIT)
  ) u0 (
    .clk(clk), .pwr_good(pwr_good), .osc_stable(osc_stable), .ext_rst(ext_rst),
    .cksum_err(cksum_err), .hw_standby(hw_standby), .hw_suspend(hw_suspend),
    .sw_suspend(sw_suspend), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .base_wr(base_wr), .base_wdata(base_wdata), .sig_wr(sig_wr), .sig_wdata(sig_wdata),
    .chip_rst(chip_rst), .part_rst(part_rst), .init_done(init_done), .init_busy(init_busy),
    .ctl_q(ctl_q), .base_q(base_q), .sig_rdata(sig_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Counts negedges with chip_rst high, starting at the current negedge.
  task automatic count_high(output int n);
    n = 0;
    while (chip_rst === 1'b1 && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    int k = 0;
    while ((part_rst !== 1'b0 || init_done !== 1'b1) && k < 5000) begin
      k++;
      @(negedge clk);
    end
  endtask

  task automatic wr_ctl(logic [15:0] d);
    ctl_wr = 1'b1; ctl_wdata = d; @(negedge clk); ctl_wr = 1'b0;
  endtask
  task automatic wr_base(logic [15:0] d);
    base_wr = 1'b1; base_wdata = d; @(negedge clk); base_wr = 1'b0;
  endtask
  task automatic wr_sig(logic [15:0] d);
    sig_wr = 1'b1; sig_wdata = d; @(negedge clk); sig_wr = 1'b0;
  endtask

  task automatic t_power_up();
    bit ok;
    @(negedge clk);
    check("R1 reset while power bad", chip_rst, 1);
    pwr_good = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset while oscillator unstable", chip_rst, 1);
    osc_stable = 1'b1;
    @(negedge clk);
    check("R1 still reset after first edge", chip_rst, 1);
    @(negedge clk);
    check("R1 released after second edge", chip_rst, 0);
    ok = 1'b1;
    for (int i = 1; i <= INIT; i++) begin
      @(negedge clk);
      if (init_done !== (i == INIT) || init_busy !== (i != INIT)) ok = 1'b0;
    end
    check("R8 init window length", ok, 1);
    check("R9 signature after power-up", sig_rdata, 16'h3000);
    check("R4 control cleared at power-up", ctl_q, 0);
  endtask

  task automatic t_ext_pin();
    bit quiet;
    int n;
    settle();
    quiet = 1'b1;
    ext_rst = 1'b1;
    for (int i = 1; i < THR; i++) begin
      @(negedge clk);
      if (chip_rst !== 1'b0) quiet = 1'b0;
    end
    ext_rst = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (chip_rst !== 1'b0) quiet = 1'b0;
    end
    check("R2 one-cycle-short pulse ignored", quiet, 1);
    ext_rst = 1'b1;
    quiet = 1'b1;
    for (int i = 1; i <= THR + 10; i++) begin
      @(negedge clk);
      if (chip_rst !== (i >= THR + 1)) quiet = 1'b0;
    end
    check("R2 qualified pulse asserts and holds", quiet, 1);
    ext_rst = 1'b0;
    count_high(n);
    check("R2 hold after pin release", n, HOLD + 1);
    settle();
  endtask

  task automatic t_cksum();
    int n;
    settle();
    cksum_err = 1'b1; @(negedge clk); cksum_err = 1'b0;
    count_high(n);
    check("R3 checksum reset length", n, HOLD);
    settle();
  endtask

  task automatic t_sw_reset();
    int n;
    settle();
    wr_ctl(16'h0041);
    check("R4 software bit starts reset", chip_rst, 1);
    wr_ctl(16'h0005);            // written during reset: must be lost
    count_high(n);
    check("R4 software reset length", n, HOLD - 1);
    check("R4 control self-cleared, write in reset ignored", ctl_q, 0);
    settle();
  endtask

  task automatic t_hw_modes();
    int n;
    for (int k = 0; k < 4; k++) begin
      settle();
      if (k < 2) hw_standby = ~hw_standby; else hw_suspend = ~hw_suspend;
      @(negedge clk);
      count_high(n);
      check("R5 mode change reset length", n, HOLD);
    end
    settle();
  endtask

  task automatic t_sw_suspend();
    int n;
    settle();
    wr_base(16'h0300);
    wr_ctl(16'h0010);
    wr_sig(16'h1234);
    check("R9 stored signature", sig_rdata, 16'h1234);
    sw_suspend = 1'b1;
    @(negedge clk);
    check("R6 partial reset on entry", {part_rst, chip_rst}, 2'b10);
    @(negedge clk);
    check("R6 base kept", base_q, 16'h0300);
    check("R6 control kept", ctl_q, 16'h0010);
    check("R6 signature restored", sig_rdata, 16'h3000);
    check("R6 init_done low", init_done, 0);
    repeat (5) @(negedge clk);
    check("R6 no chip reset while suspended", chip_rst, 0);
    sw_suspend = 1'b0;
    @(negedge clk);
    count_high(n);
    check("R7 exit reset length", n, HOLD);
    check("R7 base cleared on exit", base_q, 0);
    check("R7 control cleared on exit", ctl_q, 0);
    settle();
  endtask

  task automatic t_signature();
    int n;
    settle();
    check("R9 default signature", sig_rdata, 16'h3000);
    wr_sig(16'h0000);
    check("R9 zero write ignored", sig_rdata, 16'h3000);
    wr_sig(16'h00AB);
    check("R9 non-zero write stored", sig_rdata, 16'h00AB);
    wr_sig(16'h0000);
    check("R9 later zero write stored", sig_rdata, 16'h0000);
    cksum_err = 1'b1; @(negedge clk); cksum_err = 1'b0;
    count_high(n);
    check("R9 signature after reset", sig_rdata, 16'h3000);
    settle();
  endtask

  task automatic t_same_cycle();
    int n;
    settle();
    cksum_err = 1'b1;
    ctl_wr = 1'b1; ctl_wdata = 16'h0040;
    sig_wr = 1'b1; sig_wdata = 16'h5555;
    @(negedge clk);
    cksum_err = 1'b0; ctl_wr = 1'b0; sig_wr = 1'b0;
    count_high(n);
    check("R10 coincident causes give one reset", n, HOLD);
    check("R10 signature write lost", sig_rdata, 16'h3000);
    check("R10 control write lost", ctl_q, 0);
    settle();
  endtask

  task automatic t_power_drop();
    settle();
    wr_base(16'h0777);
    #1 pwr_good = 1'b0;
    #1;
    check("R1 asynchronous assertion", chip_rst, 1);
    check("R1 asynchronous clear", base_q, 0);
    @(negedge clk);
    pwr_good = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 release after power return", chip_rst, 0);
    settle();
    check("R8 init completes after power return", init_done, 1);
  endtask

  initial begin
    t_power_up();
    t_ext_pin();
    t_cksum();
    t_sw_reset();
    t_hw_modes();
    t_sw_suspend();
    t_signature();
    t_same_cycle();
    t_power_drop();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule